// File: doc/BRIEF.md
# Two-Domain Reset Release Sequencer

This block takes one raw active-low reset pin and produces four internal reset-type signals spread over two clock domains. On the bus side it drives a single active-high bus reset, clocked by the 66 MHz system bus clock. On the processor-core side it drives an active-high clock-setup strobe, an active-low cold reset and an active-low hot reset, all clocked by the core clock. All four outputs assert together as soon as the raw pin goes low, without waiting for any clock.

Release happens one output at a time. Each domain first passes the raw pin through its own two-flop synchronizer. A saturating counter then counts that domain's clock edges from the synchronized rising edge, and each output is freed on the edge where the count reaches its threshold. In the core domain the clock-setup strobe is freed first, then the cold reset, and the hot reset follows a fixed number of cycles after the cold reset. If the pin drops again partway through, every counter clears and every output is pulled back at once. The next rising edge starts a complete new sequence.

Top module: `reset_chain_seq`

## Requirements
- R1: While `ext_rst_n` is low, `bus_rst` = 1, `clk_setup` = 1, `cold_rst_n` = 0 and `hot_rst_n` = 0. A falling edge of `ext_rst_n` forces this state immediately, without any clock edge.
- R2: After `ext_rst_n` rises, `bus_rst` stays 1 through the 5th `bus_clk` rising edge and reads 0 after the 6th (2 synchronizer edges + `BUS_HOLD` = 4). Only `bus_clk` edges are counted.
- R3: After `ext_rst_n` rises, `clk_setup` stays 1 through the 3rd `core_clk` rising edge and reads 0 after the 4th (2 + `SETUP_HOLD` = 2).
- R4: After `ext_rst_n` rises, `cold_rst_n` stays 0 through the 17th `core_clk` rising edge and reads 1 after the 18th (2 + `COLD_HOLD` = 16).
- R5: `hot_rst_n` reads 1 exactly `HOT_HOLD` = 16 `core_clk` edges after `cold_rst_n` releases, which is the 34th edge after the rise. It stays 0 through the 33rd.
- R6: Core-domain release order is fixed: `cold_rst_n` is never 1 while `clk_setup` is 1, and `hot_rst_n` is never 1 while `cold_rst_n` is 0.
- R7: A low pulse on `ext_rst_n` in the middle of a release sequence re-asserts every output immediately. The following rise then runs the full sequence with the timing of R2 to R5.
- R8: Once released, each output stays released for as long as `ext_rst_n` stays high, however long that is, because the counters saturate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | System bus clock (66 MHz nominal) |
| core_clk | input | 1 | Processor-core clock |
| ext_rst_n | input | 1 | Raw external reset, active low, asynchronous |
| bus_rst | output | 1 | Bus-wide reset, active high, released on `bus_clk` |
| clk_setup | output | 1 | Clock-setup strobe, active high, released on `core_clk` |
| cold_rst_n | output | 1 | Core cold reset, active low, released on `core_clk` |
| hot_rst_n | output | 1 | Core hot reset, active low, released on `core_clk` |

## Verification
Each release is due on a fixed edge count after the rising edge of `ext_rst_n`: the 6th bus edge for the bus reset, and the 4th, 18th and 34th core edges for clock-setup, cold reset and hot reset. The bench changes `ext_rst_n` only at even nanosecond times. Both clocks have their rising edges only at odd times, so the synchronizer's first capturing edge is always known. Each domain counts its own edges in a parallel thread and samples 1 ns after an edge, one edge before each due release and on the due edge itself. Assertion by the falling edge is checked half a nanosecond after the drop, before any clock edge can occur.

// File: rtl/reset_chain_seq_pkg.sv
package reset_chain_seq_pkg;

  // Counter width that can hold values 0..max_val (at least one bit).
  function automatic int unsigned cnt_bits(input int unsigned max_val);
    int unsigned w;
    w = $clog2(max_val + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // Width of one tap field in a packed threshold vector.
  localparam int unsigned TAP_W = 32;

endpackage

// File: rtl/reset_chain_seq_sync.sv
module reset_chain_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic sync_o
);

  logic [STAGES-1:0] shreg;

  // Asynchronous clear, synchronous release of the high level.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      shreg <= '0;
    end else begin
      shreg <= {shreg[STAGES-2:0], 1'b1};
    end
  end

  assign sync_o = shreg[STAGES-1];

endmodule

// File: rtl/reset_chain_seq_ctr.sv
module reset_chain_seq_ctr
  import reset_chain_seq_pkg::*;
#(
  parameter int unsigned NUM_TAPS = 1,
  parameter int unsigned CNT_MAX  = 4,
  parameter logic [NUM_TAPS*TAP_W-1:0] TAPS = '0
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                run_i,
  output logic [NUM_TAPS-1:0] rel_o
);

  localparam int unsigned CW = cnt_bits(CNT_MAX);
  localparam logic [CW-1:0] LIMIT = CW'(CNT_MAX);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_limit;

  assign at_limit = (cnt_q == LIMIT);
  assign cnt_d    = (run_i && !at_limit) ? cnt_q + 1'b1 : cnt_q;

  // Saturating edge counter: holds at LIMIT until the next async clear.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // One sticky release flop per tap, set on the edge the count reaches it.
  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    localparam logic [CW-1:0] TAP_VAL = CW'(TAPS[t*TAP_W +: TAP_W]);
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        rel_o[t] <= 1'b0;
      end else if (cnt_d >= TAP_VAL) begin
        rel_o[t] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/reset_chain_seq_domain.sv
module reset_chain_seq_domain
  import reset_chain_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NUM_TAPS    = 1,
  parameter int unsigned CNT_MAX     = 4,
  parameter logic [NUM_TAPS*TAP_W-1:0] TAPS = '0
) (
  input  logic                clk,
  input  logic                arst_n,
  output logic [NUM_TAPS-1:0] rel_o
);

  logic run;

  reset_chain_seq_sync #(
    .STAGES(SYNC_STAGES)
  ) sync_i (
    .clk   (clk),
    .arst_n(arst_n),
    .sync_o(run)
  );

  reset_chain_seq_ctr #(
    .NUM_TAPS(NUM_TAPS),
    .CNT_MAX (CNT_MAX),
    .TAPS    (TAPS)
  ) ctr_i (
    .clk   (clk),
    .arst_n(arst_n),
    .run_i (run),
    .rel_o (rel_o)
  );

endmodule

// File: rtl/reset_chain_seq.sv
module reset_chain_seq
  import reset_chain_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BUS_HOLD    = 4,
  parameter int unsigned SETUP_HOLD  = 2,
  parameter int unsigned COLD_HOLD   = 16,
  parameter int unsigned HOT_HOLD    = 16
) (
  input  logic bus_clk,
  input  logic core_clk,
  input  logic ext_rst_n,
  output logic bus_rst,
  output logic clk_setup,
  output logic cold_rst_n,
  output logic hot_rst_n
);

  // Core taps share one counter; hot reset is referenced to cold release.
  localparam int unsigned HOT_TAP   = COLD_HOLD + HOT_HOLD;
  localparam int unsigned CORE_TAPS = 3;
  localparam logic [CORE_TAPS*TAP_W-1:0] CORE_TAP_VEC =
    {TAP_W'(HOT_TAP), TAP_W'(COLD_HOLD), TAP_W'(SETUP_HOLD)};
  localparam logic [TAP_W-1:0] BUS_TAP_VEC = TAP_W'(BUS_HOLD);

  logic [0:0]           bus_rel;
  logic [CORE_TAPS-1:0] core_rel;

  reset_chain_seq_domain #(
    .SYNC_STAGES(SYNC_STAGES),
    .NUM_TAPS   (1),
    .CNT_MAX    (BUS_HOLD),
    .TAPS       (BUS_TAP_VEC)
  ) bus_dom_i (
    .clk   (bus_clk),
    .arst_n(ext_rst_n),
    .rel_o (bus_rel)
  );

  reset_chain_seq_domain #(
    .SYNC_STAGES(SYNC_STAGES),
    .NUM_TAPS   (CORE_TAPS),
    .CNT_MAX    (HOT_TAP),
    .TAPS       (CORE_TAP_VEC)
  ) core_dom_i (
    .clk   (core_clk),
    .arst_n(ext_rst_n),
    .rel_o (core_rel)
  );

  assign bus_rst    = ~bus_rel[0];
  assign clk_setup  = ~core_rel[0];
  assign cold_rst_n =  core_rel[1];
  assign hot_rst_n  =  core_rel[2];

endmodule

// File: rtl/reset_chain_seq_chk.sv
module reset_chain_seq_chk (
  input logic bus_clk,
  input logic core_clk,
  input logic ext_rst_n,
  input logic bus_rst,
  input logic clk_setup,
  input logic cold_rst_n,
  input logic hot_rst_n
);

  always @(posedge core_clk) begin
    if (!ext_rst_n) begin
      AST_CORE_HELD_LOW: assert (clk_setup && !cold_rst_n && !hot_rst_n); // R1
    end
  end

  always @(posedge bus_clk) begin
    if (!ext_rst_n) begin
      AST_BUS_HELD_LOW: assert (bus_rst); // R1
    end
  end

  AST_COLD_AFTER_SETUP: assert property (@(posedge core_clk) disable iff (!ext_rst_n)
    cold_rst_n |-> !clk_setup); // R6

  AST_HOT_AFTER_COLD: assert property (@(posedge core_clk) disable iff (!ext_rst_n)
    hot_rst_n |-> cold_rst_n); // R6

  AST_COLD_RISE_HOT_LOW: assert property (@(posedge core_clk) disable iff (!ext_rst_n)
    $rose(cold_rst_n) |-> !hot_rst_n); // R5

  AST_HOT_STAYS_FREE: assert property (@(posedge core_clk) disable iff (!ext_rst_n)
    hot_rst_n |=> hot_rst_n); // R8

  AST_BUS_STAYS_FREE: assert property (@(posedge bus_clk) disable iff (!ext_rst_n)
    !bus_rst |=> !bus_rst); // R8

endmodule

bind reset_chain_seq reset_chain_seq_chk chk_i (
  .bus_clk   (bus_clk),
  .core_clk  (core_clk),
  .ext_rst_n (ext_rst_n),
  .bus_rst   (bus_rst),
  .clk_setup (clk_setup),
  .cold_rst_n(cold_rst_n),
  .hot_rst_n (hot_rst_n)
);

// File: tb/reset_chain_seq_tb_top.sv
`timescale 1ns/100ps
module reset_chain_seq_tb_top;

  // Expected release edges: 2 synchronizer edges plus each threshold.
  localparam int BUS_EDGE   = 6;
  localparam int SETUP_EDGE = 4;
  localparam int COLD_EDGE  = 18;
  localparam int HOT_EDGE   = 34;

  logic bus_clk   = 1'b0;
  logic core_clk  = 1'b0;
  logic ext_rst_n = 1'b1;
  logic bus_rst, clk_setup, cold_rst_n, hot_rst_n;

  int n_chk = 0;
  int n_err = 0;

  // 100 MHz bus clock with rising edges at 5+10k; core rising edges at 7+14k.
  // Both fall on odd times only; stimulus changes at even times.
  initial #5 forever begin bus_clk = 1'b1; #5; bus_clk = 1'b0; #5; end
  initial begin #7; forever begin core_clk = 1'b1; #7; core_clk = 1'b0; #7; end end

  reset_chain_seq dut_i (
    .bus_clk   (bus_clk),
    .core_clk  (core_clk),
    .ext_rst_n (ext_rst_n),
    .bus_rst   (bus_rst),
    .clk_setup (clk_setup),
    .cold_rst_n(cold_rst_n),
    .hot_rst_n (hot_rst_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all_asserted(input string req, input string what);
    chk(bus_rst == 1'b1,    req, {what, " bus_rst"},    int'(bus_rst), 1);
    chk(clk_setup == 1'b1,  req, {what, " clk_setup"},  int'(clk_setup), 1);
    chk(cold_rst_n == 1'b0, req, {what, " cold_rst_n"}, int'(cold_rst_n), 0);
    chk(hot_rst_n == 1'b0,  req, {what, " hot_rst_n"},  int'(hot_rst_n), 0);
  endtask

  // Raise ext_rst_n at an even time and check every release edge.
  task automatic run_timed_release(input string tag);
    @(posedge bus_clk); #1;
    ext_rst_n = 1'b1;
    fork
      begin
        for (int k = 1; k <= BUS_EDGE; k++) begin
          @(posedge bus_clk); #1;
          if (k == BUS_EDGE - 1) chk(bus_rst == 1'b1, "R2", {tag, " bus_rst edge5"}, int'(bus_rst), 1);
          if (k == BUS_EDGE)     chk(bus_rst == 1'b0, "R2", {tag, " bus_rst edge6"}, int'(bus_rst), 0);
        end
      end
      begin
        for (int k = 1; k <= HOT_EDGE; k++) begin
          @(posedge core_clk); #1;
          if (k == SETUP_EDGE - 1) chk(clk_setup == 1'b1, "R3", {tag, " clk_setup edge3"}, int'(clk_setup), 1);
          if (k == SETUP_EDGE)     chk(clk_setup == 1'b0, "R3", {tag, " clk_setup edge4"}, int'(clk_setup), 0);
          if (k == SETUP_EDGE)     chk(cold_rst_n == 1'b0, "R6", {tag, " cold low at setup release"}, int'(cold_rst_n), 0);
          if (k == COLD_EDGE - 1)  chk(cold_rst_n == 1'b0, "R4", {tag, " cold_rst_n edge17"}, int'(cold_rst_n), 0);
          if (k == COLD_EDGE)      chk(cold_rst_n == 1'b1, "R4", {tag, " cold_rst_n edge18"}, int'(cold_rst_n), 1);
          if (k == COLD_EDGE)      chk(hot_rst_n == 1'b0, "R6", {tag, " hot low at cold release"}, int'(hot_rst_n), 0);
          if (k == HOT_EDGE - 1)   chk(hot_rst_n == 1'b0, "R5", {tag, " hot_rst_n edge33"}, int'(hot_rst_n), 0);
          if (k == HOT_EDGE)       chk(hot_rst_n == 1'b1, "R5", {tag, " hot_rst_n edge34"}, int'(hot_rst_n), 1);
        end
      end
    join
  endtask

  task automatic t_reset_state();
    #1 ext_rst_n = 1'b0;
    repeat (5) @(posedge core_clk);
    #1;
    chk_all_asserted("R1", "held low");
  endtask

  task automatic t_full_release();
    run_timed_release("first");
  endtask

  task automatic t_hold_released();
    repeat (200) @(posedge core_clk);
    #1;
    chk(bus_rst == 1'b0,    "R8", "long hold bus_rst",    int'(bus_rst), 0);
    chk(clk_setup == 1'b0,  "R8", "long hold clk_setup",  int'(clk_setup), 0);
    chk(cold_rst_n == 1'b1, "R8", "long hold cold_rst_n", int'(cold_rst_n), 1);
    chk(hot_rst_n == 1'b1,  "R8", "long hold hot_rst_n",  int'(hot_rst_n), 1);
  endtask

  task automatic t_async_drop();
    @(posedge bus_clk); #1;
    ext_rst_n = 1'b0;
    #0.5;
    chk_all_asserted("R1", "async drop");
    #20;
  endtask

  task automatic t_restart_mid();
    @(posedge bus_clk); #1;
    ext_rst_n = 1'b1;
    repeat (10) @(posedge core_clk);
    #1;
    chk(clk_setup == 1'b0,  "R7", "mid setup freed",  int'(clk_setup), 0);
    chk(cold_rst_n == 1'b0, "R7", "mid cold held",    int'(cold_rst_n), 0);
    @(posedge bus_clk); #1;
    ext_rst_n = 1'b0;
    #0.5;
    chk_all_asserted("R7", "mid re-assert");
    #20;
    run_timed_release("restart R7");
  endtask

  initial begin
    t_reset_state();
    t_full_release();
    t_hold_released();
    t_async_drop();
    t_restart_mid();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired: actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule